// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host that issues configuration-space requests and a generic single-word read/write port that reaches a PCI bridge. A request carries bus, device, function, register offset, byte count (1, 2 or 4) and direction. The block checks the arguments, forms either a Type 0 or a Type 1 configuration cycle, and runs it on the back-end port. A request that cannot be serviced is answered with an error and produces no back-end cycle.

On bus 0 the target device is selected by a single set bit at position device + 16. The bits of that one-hot word that fall under the window mask go to the window output, together with the Type 0 command code. The rest are folded into the cycle address. On any other bus the window carries the Type 1 command code, and the address carries bus, device, function and register in the standard layout. Reads are shifted down to the addressed byte lane and truncated to the requested size. Sub-word writes are done as a read of the containing word, a lane merge, and a full-word write-back.

Only one request is in flight at a time: the request side is held not-ready from acceptance until the one-cycle response has been presented.

Top module: `pci_cfg_xlat`

## Requirements
- R1: The block accepts a byte count of 1, 2 or 4 on `req_size_i`. Any other value is answered with `rsp_err_o`=1 in the cycle after acceptance. It starts no back-end cycle and leaves `win_o` unchanged.
- R2: When `cardbus_en_i` is 1, a device number above 1 is rejected with an error and no back-end cycle.
- R3: On bus 0, a device number of 16 or more is rejected with an error and no back-end cycle.
- R4: Bus 0 produces a Type 0 cycle. Let S = 1 << (device+16). Then `win_o` = T0 code (2) | (S & window mask 0xFC00_0000), and `bk_addr_o` = base 0x0C00_0000 | (S & ~mask) | function<<8 | offset[7:2]<<2, with bits 1:0 = 00.
- R5: A non-zero bus produces a Type 1 cycle. `win_o` = T1 code (3), and `bk_addr_o` = base | bus<<16 | device<<11 | function<<8 | offset[7:2]<<2 | 2'b01.
- R6: A read returns (word >> 8×offset[1:0]) masked to 0xFF, 0xFFFF or the full word, for sizes 1, 2 and 4 respectively.
- R7: A 1- or 2-byte write first reads the word. It then writes back (word & ~(M << sh)) | ((data & M) << sh), where sh = 8×offset[1:0], M = 0xFF or 0xFFFF, and the result is truncated to 32 bits. A 4-byte write is a single write of the data with no read.
- R8: A back-end error on any cycle of a request gives `rsp_err_o`=1. An error on the read of a sub-word write suppresses the write-back.
- R9: `req_ready_o` is low from the cycle after acceptance through the response cycle. `rsp_valid_o` is a one-cycle pulse. `bk_valid_o` is never high while `req_ready_o` is high.
- R10: After reset, `req_ready_o`=1, `rsp_valid_o`=0, `bk_valid_o`=0 and `win_o` holds the T0 code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cardbus_en_i | input | 1 | Limits devices to 0 and 1 |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Bus number |
| req_dev_i | input | 5 | Device number |
| req_func_i | input | 3 | Function number |
| req_off_i | input | 8 | Register byte offset |
| req_size_i | input | 3 | Byte count |
| req_wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Request failed |
| rsp_rdata_o | output | 32 | Read data, right-aligned |
| win_o | output | 32 | Window register value |
| bk_valid_o | output | 1 | Back-end cycle active |
| bk_write_o | output | 1 | Back-end cycle is a write |
| bk_addr_o | output | 32 | Back-end word address |
| bk_wdata_o | output | 32 | Back-end write word |
| bk_done_i | input | 1 | Back-end cycle complete |
| bk_err_i | input | 1 | Back-end bus error with done |
| bk_rdata_i | input | 32 | Back-end read word, valid with done |

## Verification
A rejected request must answer exactly one cycle after the accepting edge. The bench counts negedges from acceptance and requires the pulse at the first one, with no back-end cycle recorded in between. For a serviced request, the first back-end cycle appears the cycle after acceptance, and each back-end cycle completes on the edge where done is sampled. The response follows one cycle after the last done, so the bench waits for the pulse while checking at every intervening negedge that ready stays low. It then checks that the pulse is gone one cycle later. A behavioural back-end with fixed latency logs every completed cycle (direction, address, word, window), and the bench compares that log against a queue of expected cycles computed from the requirements.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned DEV_W = 5;
  localparam int unsigned FUN_W = 3;
  localparam int unsigned OFF_W = 8;
  localparam int unsigned SZ_W  = 3;
  localparam int unsigned REG_W = OFF_W - 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_RSP
  } xl_state_e;

  function automatic logic size_legal(input logic [SZ_W-1:0] sz);
    return (sz == SZ_W'(1)) || (sz == SZ_W'(2)) || (sz == SZ_W'(4));
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [SZ_W-1:0] sz);
    case (sz)
      SZ_W'(1): return DW'(32'h0000_00FF);
      SZ_W'(2): return DW'(32'h0000_FFFF);
      default:  return '1;
    endcase
  endfunction
endpackage

// File: rtl/pci_cfg_addr.sv
module pci_cfg_addr
  import pci_cfg_pkg::*;
#(
  parameter logic [DW-1:0] CFG_BASE  = 32'h0C00_0000,
  parameter logic [DW-1:0] WIN_MASK  = 32'hFC00_0000,
  parameter logic [DW-1:0] T0_CODE   = 32'h0000_0002,
  parameter logic [DW-1:0] T1_CODE   = 32'h0000_0003,
  parameter int unsigned   BUS0_DEVS = 16,
  parameter int unsigned   CB_DEVS   = 2
) (
  input  logic [BUS_W-1:0] bus_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [FUN_W-1:0] func_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             cardbus_i,
  output logic             ok_o,
  output logic [DW-1:0]    win_o,
  output logic [DW-1:0]    addr_o
);
  localparam int unsigned SEL_BASE = 16;
  localparam int unsigned SH_W     = $clog2(DW + SEL_BASE) + 1;

  logic          type1;
  logic [DW-1:0] sel;
  logic [DW-1:0] reg_off;

  assign type1   = (bus_i != '0);
  assign reg_off = DW'({reg_i, 2'b00});

  always_comb begin
    sel = DW'(1) << (SH_W'(dev_i) + SH_W'(SEL_BASE));
    ok_o = size_legal(size_i);
    if (cardbus_i && (32'(dev_i) >= CB_DEVS)) ok_o = 1'b0;
    if (!type1 && (32'(dev_i) >= BUS0_DEVS))  ok_o = 1'b0;
    if (type1) begin
      win_o  = T1_CODE;
      addr_o = CFG_BASE | (DW'(bus_i) << 16) | (DW'(dev_i) << 11)
             | (DW'(func_i) << 8) | reg_off | DW'(1);
    end else begin
      win_o  = T0_CODE | (sel & WIN_MASK);
      addr_o = CFG_BASE | (sel & ~WIN_MASK) | (DW'(func_i) << 8) | reg_off;
    end
  end
endmodule

// File: rtl/pci_cfg_lane.sv
module pci_cfg_lane
  import pci_cfg_pkg::*;
(
  input  logic [DW-1:0]   word_i,
  input  logic [1:0]      lane_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   rd_o,
  output logic [DW-1:0]   merged_o
);
  logic [4:0]    sh;
  logic [DW-1:0] m;

  assign sh = {lane_i, 3'b000};
  assign m  = lane_mask(size_i);

  always_comb begin
    rd_o     = (word_i >> sh) & m;
    merged_o = (word_i & ~(m << sh)) | ((data_i & m) << sh);
  end
endmodule

// File: rtl/pci_cfg_xlat.sv
module pci_cfg_xlat
  import pci_cfg_pkg::*;
#(
  parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
  parameter logic [31:0] WIN_MASK  = 32'hFC00_0000,
  parameter logic [31:0] T0_CODE   = 32'h0000_0002,
  parameter logic [31:0] T1_CODE   = 32'h0000_0003,
  parameter int unsigned BUS0_DEVS = 16,
  parameter int unsigned CB_DEVS   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cardbus_en_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_bus_i,
  input  logic [4:0]  req_dev_i,
  input  logic [2:0]  req_func_i,
  input  logic [7:0]  req_off_i,
  input  logic [2:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic        rsp_err_o,
  output logic [31:0] rsp_rdata_o,
  output logic [31:0] win_o,
  output logic        bk_valid_o,
  output logic        bk_write_o,
  output logic [31:0] bk_addr_o,
  output logic [31:0] bk_wdata_o,
  input  logic        bk_done_i,
  input  logic        bk_err_i,
  input  logic [31:0] bk_rdata_i
);
  xl_state_e       st_q;
  logic [DW-1:0]   win_q, addr_q, wd_q, rd_q;
  logic            err_q, wr_q;
  logic [1:0]      lane_q;
  logic [SZ_W-1:0] sz_q;

  logic            a_ok;
  logic [DW-1:0]   a_win, a_addr;
  logic [DW-1:0]   l_rd, l_merged;
  logic            accept;

  pci_cfg_addr #(
    .CFG_BASE (CFG_BASE),
    .WIN_MASK (WIN_MASK),
    .T0_CODE  (T0_CODE),
    .T1_CODE  (T1_CODE),
    .BUS0_DEVS(BUS0_DEVS),
    .CB_DEVS  (CB_DEVS)
  ) u_addr (
    .bus_i    (req_bus_i),
    .dev_i    (req_dev_i),
    .func_i   (req_func_i),
    .reg_i    (req_off_i[OFF_W-1:2]),
    .size_i   (req_size_i),
    .cardbus_i(cardbus_en_i),
    .ok_o     (a_ok),
    .win_o    (a_win),
    .addr_o   (a_addr)
  );

  pci_cfg_lane u_lane (
    .word_i  (bk_rdata_i),
    .lane_i  (lane_q),
    .size_i  (sz_q),
    .data_i  (wd_q),
    .rd_o    (l_rd),
    .merged_o(l_merged)
  );

  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      win_q  <= T0_CODE;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      lane_q <= '0;
      sz_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          wr_q   <= req_write_i;
          lane_q <= req_off_i[1:0];
          sz_q   <= req_size_i;
          wd_q   <= req_wdata_i;
          rd_q   <= '0;
          if (!a_ok) begin
            err_q <= 1'b1;
            st_q  <= ST_RSP;
          end else begin
            err_q  <= 1'b0;
            win_q  <= a_win;
            addr_q <= a_addr;
            // full-word writes skip the read
            st_q   <= (req_write_i && req_size_i == SZ_W'(4)) ? ST_WR : ST_RD;
          end
        end
        ST_RD: if (bk_done_i) begin
          if (bk_err_i) begin
            err_q <= 1'b1;
            st_q  <= ST_RSP;
          end else if (wr_q) begin
            wd_q <= l_merged;
            st_q <= ST_WR;
          end else begin
            rd_q <= l_rd;
            st_q <= ST_RSP;
          end
        end
        ST_WR: if (bk_done_i) begin
          err_q <= bk_err_i;
          st_q  <= ST_RSP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_err_o   = err_q;
  assign rsp_rdata_o = rd_q;
  assign win_o       = win_q;
  assign bk_valid_o  = (st_q == ST_RD) || (st_q == ST_WR);
  assign bk_write_o  = (st_q == ST_WR);
  assign bk_addr_o   = addr_q;
  assign bk_wdata_o  = wd_q;

  a_r1_bad_size_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !(req_size_i inside {3'd1, 3'd2, 3'd4}))
      |=> (rsp_valid_o && rsp_err_o && !bk_valid_o && $stable(win_o)));

  a_r2_cardbus_dev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && cardbus_en_i && (req_dev_i > 5'd1))
      |=> (rsp_valid_o && rsp_err_o));

  a_r3_bus0_dev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_bus_i == 8'd0) && (req_dev_i >= 5'd16))
      |=> (rsp_valid_o && rsp_err_o));

  a_r4_t0_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bk_valid_o && !bk_addr_o[0])
      |-> (((win_o & ~WIN_MASK) == T0_CODE)
           && $onehot((win_o & WIN_MASK) | (bk_addr_o & ~WIN_MASK & 32'hFFFF_0000))));

  a_r5_t1_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bk_valid_o && bk_addr_o[0]) |-> (win_o == T1_CODE));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bk_valid_o && !bk_done_i)
      |=> (bk_valid_o && $stable(bk_addr_o) && $stable(bk_write_o)));

  a_r8_no_wb_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bk_valid_o && !bk_write_o && bk_done_i && bk_err_i) |=> !bk_valid_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!bk_valid_o && !rsp_valid_o));

  a_r9_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: tb/pci_cfg_xlat_tb_top.sv
`timescale 1ns/1ps
module pci_cfg_xlat_tb_top;
  localparam logic [31:0] BASE = 32'h0C00_0000;
  localparam logic [31:0] MASK = 32'hFC00_0000;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cb = 1'b0, rq_v = 1'b0, rq_w = 1'b0;
  logic [7:0]  rq_bus = '0, rq_off = '0;
  logic [4:0]  rq_dev = '0;
  logic [2:0]  rq_fn = '0, rq_sz = '0;
  logic [31:0] rq_wd = '0;
  logic        rq_rdy, rs_v, rs_e, bk_v, bk_w;
  logic [31:0] rs_d, win, bk_a, bk_wd;
  logic        bk_done = 1'b0, bk_err = 1'b0;
  logic [31:0] bk_rd = '0;

  pci_cfg_xlat dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cardbus_en_i(cb),
    .req_valid_i(rq_v), .req_ready_o(rq_rdy), .req_write_i(rq_w),
    .req_bus_i(rq_bus), .req_dev_i(rq_dev), .req_func_i(rq_fn),
    .req_off_i(rq_off), .req_size_i(rq_sz), .req_wdata_i(rq_wd),
    .rsp_valid_o(rs_v), .rsp_err_o(rs_e), .rsp_rdata_o(rs_d), .win_o(win),
    .bk_valid_o(bk_v), .bk_write_o(bk_w), .bk_addr_o(bk_a), .bk_wdata_o(bk_wd),
    .bk_done_i(bk_done), .bk_err_i(bk_err), .bk_rdata_i(bk_rd)
  );

  int errors = 0, checks = 0;
  logic [31:0] mem [logic [31:0]];
  bit          o_wr [$];
  logic [31:0] o_addr [$], o_data [$], o_win [$];
  int inj_op = 0, op_n = 0, lat = 0;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_1234);
  endfunction

  function automatic logic [31:0] lm(input logic [2:0] s);
    return (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // behavioural back end: done after LAT cycles of valid, logged per cycle
  always @(negedge clk) begin
    bk_done = 1'b0;
    bk_err  = 1'b0;
    if (bk_v) begin
      if (lat == LAT) begin
        lat = 0;
        op_n++;
        bk_done = 1'b1;
        bk_err  = (op_n == inj_op);
        o_wr.push_back(bk_w);
        o_addr.push_back(bk_a);
        o_win.push_back(win);
        if (bk_w) begin
          o_data.push_back(bk_wd);
          if (!bk_err) mem[bk_a] = bk_wd;
        end else begin
          bk_rd = rd_mem(bk_a);
          o_data.push_back(bk_rd);
        end
      end else lat++;
    end else lat = 0;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                        input logic [2:0] fn, input logic [7:0] off, input logic [2:0] sz,
                        input logic [31:0] wd, input int inj, input string rq);
    bit ok, t1, exp_err;
    logic [31:0] sel, ew, ea, old, erd, merged;
    int cyc, nexp;
    bit          e_wr [$];
    logic [31:0] e_addr [$], e_data [$];
    logic [31:0] win_before;
    int sh;
    t1  = (bus != 0);
    ok  = (sz == 1 || sz == 2 || sz == 4) && !(cb && dev > 1) && !(!t1 && dev >= 16);
    sel = 32'h1 << (dev + 16);
    sh  = 8 * off[1:0];
    if (t1) begin
      ew = 32'h3;
      ea = BASE | (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | 32'(off & 8'hFC) | 32'h1;
    end else begin
      ew = 32'h2 | (sel & MASK);
      ea = BASE | (sel & ~MASK) | (32'(fn) << 8) | 32'(off & 8'hFC);
    end
    old     = rd_mem(ea);
    erd     = (old >> sh) & lm(sz);
    merged  = (old & ~(lm(sz) << sh)) | ((wd & lm(sz)) << sh);
    exp_err = !ok;
    if (ok) begin
      if (wr && sz == 4) begin
        e_wr.push_back(1); e_addr.push_back(ea); e_data.push_back(wd);
        if (inj == 1) exp_err = 1;
      end else begin
        e_wr.push_back(0); e_addr.push_back(ea); e_data.push_back(old);
        if (inj == 1) exp_err = 1;
        else if (wr) begin
          e_wr.push_back(1); e_addr.push_back(ea); e_data.push_back(merged);
          if (inj == 2) exp_err = 1;
        end
      end
    end
    o_wr.delete(); o_addr.delete(); o_data.delete(); o_win.delete();
    op_n = 0; inj_op = inj;
    win_before = win;
    chk(rq_rdy, "R9", "ready before request", 32'(rq_rdy), 1);
    rq_w = wr; rq_bus = bus; rq_dev = dev; rq_fn = fn; rq_off = off; rq_sz = sz; rq_wd = wd;
    rq_v = 1'b1;
    @(negedge clk);
    rq_v = 1'b0;
    cyc = 1;
    while (!rs_v && cyc < 100) begin
      chk(!rq_rdy, "R9", "ready while busy", 32'(rq_rdy), 0);
      @(negedge clk);
      cyc++;
    end
    chk(rs_v, "R9", "response seen", 32'(rs_v), 1);
    chk(!rq_rdy, "R9", "ready during response", 32'(rq_rdy), 0);
    chk(rs_e == exp_err, rq, "rsp_err", 32'(rs_e), 32'(exp_err));
    if (!ok) begin
      chk(cyc == 1, rq, "reject latency", cyc, 1);
      chk(win == win_before, rq, "window unchanged", win, win_before);
    end
    nexp = e_wr.size();
    chk(o_wr.size() == nexp, rq, "back-end cycle count", o_wr.size(), nexp);
    if (o_wr.size() == nexp)
      for (int i = 0; i < nexp; i++) begin
        chk(o_wr[i] == e_wr[i], rq, "cycle direction", 32'(o_wr[i]), 32'(e_wr[i]));
        chk(o_addr[i] == e_addr[i], t1 ? "R5" : "R4", "cycle address", o_addr[i], e_addr[i]);
        chk(o_win[i] == ew, t1 ? "R5" : "R4", "window", o_win[i], ew);
        chk(o_data[i] == e_data[i], wr ? "R7" : "R6", "cycle data", o_data[i], e_data[i]);
      end
    if (ok && !wr && !exp_err) chk(rs_d == erd, "R6", "read data", rs_d, erd);
    @(negedge clk);
    chk(!rs_v, "R9", "response pulse width", 32'(rs_v), 0);
    chk(rq_rdy, "R9", "ready after response", 32'(rq_rdy), 1);
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", wd_cnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rq_rdy, "R10", "ready", 32'(rq_rdy), 1);
    chk(!rs_v, "R10", "rsp_valid", 32'(rs_v), 0);
    chk(!bk_v, "R10", "bk_valid", 32'(bk_v), 0);
    chk(win == 32'h2, "R10", "window", win, 32'h2);
    // R4/R6 Type 0 reads, one-hot below and inside the mask
    do_req(0, 8'd0, 5'd3,  3'd1, 8'h10, 3'd4, 0, 0, "R4");
    do_req(0, 8'd0, 5'd12, 3'd0, 8'h0E, 3'd1, 0, 0, "R6");
    do_req(0, 8'd0, 5'd15, 3'd7, 8'h06, 3'd2, 0, 0, "R6");
    // R5 Type 1 reads
    do_req(0, 8'd5, 5'd7,  3'd2, 8'h3F, 3'd1, 0, 0, "R5");
    do_req(0, 8'd1, 5'd16, 3'd0, 8'h00, 3'd4, 0, 0, "R5");
    // R7 sub-word and full-word writes
    do_req(1, 8'd0, 5'd2, 3'd0, 8'h05, 3'd1, 32'hABCD_EF5C, 0, "R7");
    do_req(1, 8'd2, 5'd1, 3'd3, 8'h0A, 3'd2, 32'h1234_BEEF, 0, "R7");
    do_req(0, 8'd2, 5'd1, 3'd3, 8'h08, 3'd4, 0, 0, "R7");
    do_req(1, 8'd0, 5'd0, 3'd0, 8'h20, 3'd4, 32'hCAFE_F00D, 0, "R7");
    do_req(1, 8'd0, 5'd9, 3'd1, 8'h33, 3'd2, 32'h0000_77A1, 0, "R7");
    do_req(0, 8'd0, 5'd9, 3'd1, 8'h30, 3'd4, 0, 0, "R7");
    // R1 illegal sizes
    do_req(0, 8'd0, 5'd4, 3'd0, 8'h00, 3'd3, 0, 0, "R1");
    do_req(1, 8'd3, 5'd4, 3'd0, 8'h00, 3'd0, 32'h1, 0, "R1");
    do_req(0, 8'd0, 5'd4, 3'd0, 8'h04, 3'd7, 0, 0, "R1");
    // R2 cardbus limit
    cb = 1'b1;
    do_req(0, 8'd0, 5'd2, 3'd0, 8'h00, 3'd4, 0, 0, "R2");
    do_req(0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd4, 0, 0, "R2");
    do_req(0, 8'd4, 5'd3, 3'd0, 8'h00, 3'd4, 0, 0, "R2");
    cb = 1'b0;
    // R3 bus 0 device limit
    do_req(0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 0, 0, "R3");
    do_req(1, 8'd0, 5'd31, 3'd0, 8'h00, 3'd1, 32'h5, 0, "R3");
    // R8 bus errors
    do_req(0, 8'd0, 5'd5, 3'd0, 8'h40, 3'd4, 0, 1, "R8");
    do_req(1, 8'd0, 5'd5, 3'd0, 8'h41, 3'd1, 32'h99, 1, "R8");
    do_req(1, 8'd6, 5'd5, 3'd0, 8'h42, 3'd2, 32'h9988, 2, "R8");
    do_req(1, 8'd0, 5'd6, 3'd0, 8'h44, 3'd4, 32'h1111_2222, 1, "R8");
    do_req(0, 8'd0, 5'd6, 3'd0, 8'h44, 3'd4, 0, 0, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule